// File: doc/BRIEF.md
# NAND Page Read Command Sequencer

This block turns one read request into the ordered list of bus steps that a raw NAND bus engine executes: command bytes, address bytes and a final data-in burst. Between steps it inserts fixed waits and a busy wait on the device's ready/busy line. Two request kinds are handled. A page read loads a page from the array and then streams it out. A column change moves the read pointer inside a page that is already loaded, without another array read.

The request carries the page number, the byte offset, the burst length and three flags: a large-device flag that adds a third row byte, a 16-bit bus flag that halves the offset, and a destination flag that decides whether a page read ends with a burst. Every step goes to the engine over a valid/ack handshake. The engine can refuse a step with an error flag, and that stops the sequence.

States: `S_IDLE` (waits for a request), `S_CMD1` (first opcode), `S_ADDR` (address bytes), `S_CMD2` (second opcode), `S_TWB` (fixed wait after the read opcode), `S_RDY` (busy wait with timeout), `S_TRR` (fixed wait before the burst), `S_TCCS` (fixed wait after a column change), `S_DATA` (burst step), `S_END` (one-cycle completion). Transitions:
- `S_IDLE`→`S_CMD1` when a request is accepted.
- `S_CMD1`→`S_ADDR` and `S_CMD2`→`S_TWB` or `S_TCCS` on an acknowledged step.
- `S_ADDR`→`S_ADDR` or `S_CMD2` on an acknowledged step.
- `S_TWB`→`S_RDY` when the wait has elapsed.
- `S_RDY`→`S_TRR` when the device is ready, or `S_RDY`→`S_END` on timeout.
- `S_TRR`→`S_DATA` or `S_END` when the wait has elapsed.
- `S_TCCS`→`S_DATA` when the wait has elapsed.
- `S_DATA`→`S_END` on an acknowledged step.
- Any step state→`S_END` on a step error.
- `S_END`→`S_IDLE`.

Top module: `nand_read_seq`

## Requirements
- R1: After reset, busy, done and op_valid are all low, and error_code is 0.
- R2: A request is accepted only when busy is low and req_valid is high. From the next cycle busy stays high until the cycle after the done pulse. A request presented while busy is ignored and produces no step.
- R3: A page read (req_kind=0) issues, in order: command 0x00, the address bytes, command 0x30, then one data step whose length is req_len, and then done with error_code 0.
- R4: The column takes two address bytes, low byte first. When req_wide=1 the column value is req_offset shifted right by one, otherwise it is req_offset.
- R5: After the column bytes, a page read sends page bits 7:0 and then bits 15:8. A third byte, bits 23:16, follows only when req_big=1.
- R6: A fixed wait of setting N lasts N+1 cycles. In a page read with the device ready, the data step appears cfg_twb+cfg_trr+4 cycles after the cycle in which command 0x30 is acknowledged. In a column change it appears cfg_tccs+2 cycles after command 0xE0 is acknowledged.
- R7: The busy wait holds off the data step while dev_ready is low. If dev_ready stays low for cfg_tr_max+1 cycles in that state, the sequence ends with error_code 2 and no data step. With cfg_twb as the first wait, done then appears cfg_twb+cfg_tr_max+3 cycles after command 0x30 is acknowledged.
- R8: A page read with req_dest=0 issues no data step. Done appears cfg_twb+cfg_trr+4 cycles after command 0x30 is acknowledged.
- R9: A column change (req_kind=1) issues, in order: command 0x05, two column bytes, command 0xE0, then the data step, and then done.
- R10: Step codes on op_kind are 0 for a command, 1 for an address and 2 for a data burst. A step holds op_valid, op_kind and op_byte stable until op_ack. Each acknowledged step is followed by the next step one cycle later, unless a wait lies between them.
- R11: A step acknowledged with op_err high ends the sequence. Done with error_code 1 appears in the next cycle, and no further step is issued.
- R12: Done is a one-cycle pulse. error_code is nonzero only while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 1 | 0 page read, 1 column change |
| req_page | input | PAGE_W | Page number |
| req_offset | input | OFS_W | Byte offset in the page |
| req_len | input | LEN_W | Burst length |
| req_big | input | 1 | Device larger than 128 MiB (adds a third row byte) |
| req_wide | input | 1 | 16-bit data bus |
| req_dest | input | 1 | Page read ends with a burst |
| cfg_twb | input | WAIT_W | Wait after read opcode, in cycles |
| cfg_trr | input | WAIT_W | Wait before burst, in cycles |
| cfg_tccs | input | WAIT_W | Wait after column change opcode, in cycles |
| cfg_tr_max | input | TR_W | Busy wait timeout, in cycles |
| dev_ready | input | 1 | Device ready (high) / busy (low) |
| op_valid | output | 1 | Step valid to bus engine |
| op_kind | output | 2 | Step kind code |
| op_byte | output | 8 | Opcode or address byte |
| op_len | output | LEN_W | Burst length for a data step |
| op_ack | input | 1 | Engine accepted the step |
| op_err | input | 1 | Engine reports failure of the step |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| error_code | output | 2 | 0 ok, 1 step error, 2 ready timeout |

## Verification
Each step is due exactly one cycle after the previous one is acknowledged. Across a wait the delay follows from the settings: cfg_tccs+2 cycles after the column change opcode, cfg_twb+cfg_trr+4 cycles after the read opcode with the device ready, and cfg_twb+cfg_tr_max+3 cycles to a timeout done. The bench keeps a queue of expected steps. Each entry holds its expected distance in cycles from the previous acknowledge, and the bench counts posedges and compares that distance at the falling edge where the step is first seen. For a busy wait of unknown length only a lower bound is checked. The done pulse is timed in the same way from the last acknowledge.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_TWB, S_RDY, S_TRR, S_TCCS, S_DATA, S_END
    } nrs_state_e;

    localparam logic [1:0] K_CMD  = 2'd0;
    localparam logic [1:0] K_ADDR = 2'd1;
    localparam logic [1:0] K_DATA = 2'd2;

    localparam logic [7:0] OPC_READ_A = 8'h00;
    localparam logic [7:0] OPC_READ_B = 8'h30;
    localparam logic [7:0] OPC_COL_A  = 8'h05;
    localparam logic [7:0] OPC_COL_B  = 8'hE0;

    localparam logic [1:0] E_NONE    = 2'd0;
    localparam logic [1:0] E_STEP    = 2'd1;
    localparam logic [1:0] E_TIMEOUT = 2'd2;
endpackage

// File: rtl/nrs_addr_gen.sv
module nrs_addr_gen #(
    parameter int OFS_W  = 16,
    parameter int PAGE_W = 24
) (
    input  logic [OFS_W-1:0]  offset,
    input  logic [PAGE_W-1:0] page,
    input  logic              wide,
    input  logic [2:0]        idx,
    output logic [7:0]        abyte
);
    localparam int COL_BYTES = 2;
    localparam int ROW_BYTES = 3;
    localparam int NSLOT     = COL_BYTES + ROW_BYTES;

    logic [8*COL_BYTES-1:0] col_v;
    logic [8*ROW_BYTES-1:0] row_v;
    logic [7:0]             slot [NSLOT];

    assign col_v = (8*COL_BYTES)'(wide ? (offset >> 1) : offset);
    assign row_v = (8*ROW_BYTES)'(page);

    for (genvar g = 0; g < COL_BYTES; g++) begin : g_col
        assign slot[g] = col_v[8*g +: 8];
    end
    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_row
        assign slot[COL_BYTES+g] = row_v[8*g +: 8];
    end

    always_comb begin
        abyte = 8'h00;
        for (int i = 0; i < NSLOT; i++) begin
            if (idx == 3'(i)) abyte = slot[i];
        end
    end
endmodule

// File: rtl/nrs_wait_timer.sv
module nrs_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/nand_read_seq.sv
module nand_read_seq
    import nrs_pkg::*;
#(
    parameter int PAGE_W = 24,
    parameter int OFS_W  = 16,
    parameter int LEN_W  = 16,
    parameter int WAIT_W = 8,
    parameter int TR_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_kind,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_big,
    input  logic              req_wide,
    input  logic              req_dest,
    input  logic [WAIT_W-1:0] cfg_twb,
    input  logic [WAIT_W-1:0] cfg_trr,
    input  logic [WAIT_W-1:0] cfg_tccs,
    input  logic [TR_W-1:0]   cfg_tr_max,
    input  logic              dev_ready,
    output logic              op_valid,
    output logic [1:0]        op_kind,
    output logic [7:0]        op_byte,
    output logic [LEN_W-1:0]  op_len,
    input  logic              op_ack,
    input  logic              op_err,
    output logic              busy,
    output logic              done,
    output logic [1:0]        error_code
);
    localparam int TMR_W = (WAIT_W > TR_W) ? WAIT_W : TR_W;

    nrs_state_e state, nxt;

    logic              r_kind, r_big, r_wide, r_dest;
    logic [PAGE_W-1:0] r_page;
    logic [OFS_W-1:0]  r_ofs;
    logic [LEN_W-1:0]  r_len;
    logic [2:0]        idx;
    logic [2:0]        last_idx;
    logic [1:0]        err_q;
    logic [7:0]        addr_byte;
    logic              t_load, t_zero;
    logic [TMR_W-1:0]  t_val;
    logic              step_ok, step_bad;

    assign last_idx = r_kind ? 3'd1 : (r_big ? 3'd4 : 3'd3);
    assign step_ok  = op_ack && !op_err;
    assign step_bad = op_ack && op_err;

    nrs_addr_gen #(.OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_addr (
        .offset(r_ofs), .page(r_page), .wide(r_wide), .idx(idx), .abyte(addr_byte)
    );

    always_comb begin
        t_load = (nxt != state) &&
                 (nxt == S_TWB || nxt == S_RDY || nxt == S_TRR || nxt == S_TCCS);
        unique case (nxt)
            S_TWB:   t_val = TMR_W'(cfg_twb);
            S_RDY:   t_val = TMR_W'(cfg_tr_max);
            S_TRR:   t_val = TMR_W'(cfg_trr);
            S_TCCS:  t_val = TMR_W'(cfg_tccs);
            default: t_val = '0;
        endcase
    end

    nrs_wait_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (req_valid) nxt = S_CMD1;
            S_CMD1: if (step_bad) nxt = S_END; else if (step_ok) nxt = S_ADDR;
            S_ADDR: if (step_bad) nxt = S_END;
                    else if (step_ok) nxt = (idx == last_idx) ? S_CMD2 : S_ADDR;
            S_CMD2: if (step_bad) nxt = S_END;
                    else if (step_ok) nxt = r_kind ? S_TCCS : S_TWB;
            S_TWB:  if (t_zero) nxt = S_RDY;
            S_RDY:  if (dev_ready) nxt = S_TRR; else if (t_zero) nxt = S_END;
            S_TRR:  if (t_zero) nxt = r_dest ? S_DATA : S_END;
            S_TCCS: if (t_zero) nxt = S_DATA;
            S_DATA: if (op_ack) nxt = S_END;
            S_END:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            idx    <= '0;
            err_q  <= E_NONE;
            r_kind <= 1'b0;
            r_big  <= 1'b0;
            r_wide <= 1'b0;
            r_dest <= 1'b0;
            r_page <= '0;
            r_ofs  <= '0;
            r_len  <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && req_valid) begin
                r_kind <= req_kind;
                r_big  <= req_big;
                r_wide <= req_wide;
                r_dest <= req_dest;
                r_page <= req_page;
                r_ofs  <= req_offset;
                r_len  <= req_len;
                idx    <= '0;
                err_q  <= E_NONE;
            end
            if (state == S_ADDR && step_ok) idx <= idx + 3'd1;
            if (op_valid && step_bad) err_q <= E_STEP;
            if (state == S_RDY && !dev_ready && t_zero) err_q <= E_TIMEOUT;
        end
    end

    // outputs
    always_comb begin
        op_valid   = 1'b0;
        op_kind    = K_CMD;
        op_byte    = 8'h00;
        op_len     = '0;
        busy       = (state != S_IDLE);
        done       = (state == S_END);
        error_code = (state == S_END) ? err_q : E_NONE;
        unique case (state)
            S_CMD1: begin
                op_valid = 1'b1;
                op_byte  = r_kind ? OPC_COL_A : OPC_READ_A;
            end
            S_ADDR: begin
                op_valid = 1'b1;
                op_kind  = K_ADDR;
                op_byte  = addr_byte;
            end
            S_CMD2: begin
                op_valid = 1'b1;
                op_byte  = r_kind ? OPC_COL_B : OPC_READ_B;
            end
            S_DATA: begin
                op_valid = 1'b1;
                op_kind  = K_DATA;
                op_len   = r_len;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nrs_chk.sv
module nrs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       busy,
    input logic       done,
    input logic [1:0] error_code,
    input logic       op_valid,
    input logic [1:0] op_kind,
    input logic [7:0] op_byte,
    input logic       op_ack,
    input logic       op_err
);
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !op_valid);

    // R10
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ack) |=> (op_valid && $stable(op_byte) && $stable(op_kind)));

    // R11
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ack && op_err) |=> (done && error_code == 2'd1));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    code_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error_code != 2'd0) |-> (done && busy));
endmodule

bind nand_read_seq nrs_chk u_nrs_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
    .error_code(error_code), .op_valid(op_valid), .op_kind(op_kind),
    .op_byte(op_byte), .op_ack(op_ack), .op_err(op_err)
);

// File: tb/test_nand_read_seq.sv
module test_nand_read_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_kind = 1'b0, req_big = 1'b0, req_wide = 1'b0, req_dest = 1'b0;
    logic [23:0] req_page = '0;
    logic [15:0] req_offset = '0, req_len = '0;
    logic [7:0]  cfg_twb = 8'd3, cfg_trr = 8'd2, cfg_tccs = 8'd4;
    logic [15:0] cfg_tr_max = 16'd20;
    logic        dev_ready = 1'b1;
    logic        op_valid, busy, done;
    logic [1:0]  op_kind, error_code;
    logic [7:0]  op_byte;
    logic [15:0] op_len;
    logic        op_ack = 1'b0, op_err = 1'b0;

    nand_read_seq i_nand_read_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_page(req_page), .req_offset(req_offset), .req_len(req_len),
        .req_big(req_big), .req_wide(req_wide), .req_dest(req_dest),
        .cfg_twb(cfg_twb), .cfg_trr(cfg_trr), .cfg_tccs(cfg_tccs), .cfg_tr_max(cfg_tr_max),
        .dev_ready(dev_ready), .op_valid(op_valid), .op_kind(op_kind), .op_byte(op_byte),
        .op_len(op_len), .op_ack(op_ack), .op_err(op_err), .busy(busy), .done(done),
        .error_code(error_code)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    int last_ack = 0, n_ops = 0, err_at = -1, rdy_low = 0, hold_n = 0;
    bit stuck = 1'b0;
    int q_kind[$], q_byte[$], q_len[$], q_gap[$], q_req[$];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(int k, int b, int l, int g, int r);
        q_kind.push_back(k); q_byte.push_back(b); q_len.push_back(l);
        q_gap.push_back(g); q_req.push_back(r);
    endtask

    // gap >= 0: exact distance from previous ack; gap < 0: at least -gap
    always @(negedge clk) begin
        if (rst_n && op_valid) begin
            if (q_kind.size() == 0) begin
                chk(1'b0, "R2", "unexpected step byte", int'(op_byte), -1);
            end else begin
                int k, b, l, g, r, act, exp, gap;
                k = q_kind.pop_front(); b = q_byte.pop_front(); l = q_len.pop_front();
                g = q_gap.pop_front(); r = q_req.pop_front();
                act = int'(op_kind) * 65536 * 256 + int'(op_byte) * 65536 + int'(op_len);
                exp = k * 65536 * 256 + b * 65536 + l;
                chk(act == exp, $sformatf("R%0d", r), "step kind/byte/len", act, exp);
                gap = cyc - last_ack;
                if (g >= 0) chk(gap == g, (k == 2) ? "R6" : "R10", "step gap", gap, g);
                else        chk(gap >= -g, "R7", "step gap minimum", gap, -g);
            end
            n_ops++;
            op_err = (n_ops == err_at);
            op_ack = 1'b1;
            last_ack = cyc;
            if (op_kind == 2'd0 && op_byte == 8'h30 && hold_n > 0) rdy_low = hold_n;
        end else begin
            op_ack = 1'b0;
            op_err = 1'b0;
        end
        dev_ready = !(stuck || rdy_low > 0);
        if (rdy_low > 0) rdy_low--;
    end

    function automatic int colv(int ofs, bit wide);
        return wide ? (ofs >> 1) : ofs;
    endfunction

    // full expected page read step list
    task automatic exp_page(int page, int ofs, int len, bit big, bit wide, bit dest, int dgap);
        int c;
        c = colv(ofs, wide);
        push(0, 8'h00, 0, 1, 3);
        push(1, c & 255, 0, 1, 4);
        push(1, (c >> 8) & 255, 0, 1, 4);
        push(1, page & 255, 0, 1, 5);
        push(1, (page >> 8) & 255, 0, 1, 5);
        if (big) push(1, (page >> 16) & 255, 0, 1, 5);
        push(0, 8'h30, 0, 1, 3);
        if (dest) push(2, 0, len, dgap, 3);
    endtask

    task automatic run(string tag, bit kind, int page, int ofs, int len, bit big, bit wide,
                       bit dest, int e_at, bit stk, int hold, bit intrude,
                       int done_gap, int code, string dreq);
        bit seen;
        err_at = e_at; stuck = stk; hold_n = hold; n_ops = 0;
        @(negedge clk);
        req_kind = kind; req_page = 24'(page); req_offset = 16'(ofs); req_len = 16'(len);
        req_big = big; req_wide = wide; req_dest = dest; req_valid = 1'b1;
        last_ack = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R2", {tag, " busy after accept"}, int'(busy), 1);
        if (intrude) begin
            req_kind = ~kind; req_page = 24'hABCDEF; req_valid = 1'b1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                if (done_gap >= 0)
                    chk(cyc - last_ack == done_gap, dreq, {tag, " done timing"}, cyc - last_ack, done_gap);
                chk(int'(error_code) == code, dreq, {tag, " error code"}, int'(error_code), code);
                chk(q_kind.size() == 0, dreq, {tag, " missing steps"}, q_kind.size(), 0);
            end
        end
        if (!seen) chk(1'b0, dreq, {tag, " no done"}, 0, 1);
        @(negedge clk);
        chk(!done && !busy, "R12", {tag, " done one cycle, busy drops"}, int'({done, busy}), 0);
        q_kind.delete(); q_byte.delete(); q_len.delete(); q_gap.delete(); q_req.delete();
        stuck = 1'b0; err_at = -1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !op_valid && error_code == 2'd0, "R1", "reset state",
            int'({busy, done, op_valid, error_code}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5 narrow, small device, with intruding request (R2)
        exp_page(24'h12A55C, 16'h0234, 512, 0, 0, 1, 3 + 2 + 4);
        run("page_narrow", 0, 24'h12A55C, 16'h0234, 512, 0, 0, 1, -1, 0, 0, 1, 1, 0, "R3");

        // R4 R5 wide bus halves offset, big device adds third row byte
        exp_page(24'h9E3701, 16'h0F86, 64, 1, 1, 1, 3 + 2 + 4);
        run("page_wide_big", 0, 24'h9E3701, 16'h0F86, 64, 1, 1, 1, -1, 0, 0, 0, 1, 0, "R5");

        // R8 no destination: no data step
        exp_page(24'h000010, 16'h0000, 8, 0, 0, 0, 0);
        run("page_nodest", 0, 24'h000010, 0, 8, 0, 0, 0, -1, 0, 0, 0, 3 + 2 + 4, 0, "R8");

        // R9 R6 column change on 16-bit bus
        push(0, 8'h05, 0, 1, 9);
        push(1, colv(16'h0402, 1) & 255, 0, 1, 4);
        push(1, (colv(16'h0402, 1) >> 8) & 255, 0, 1, 4);
        push(0, 8'hE0, 0, 1, 9);
        push(2, 0, 100, 4 + 2, 9);
        run("colchg", 1, 0, 16'h0402, 100, 0, 1, 1, -1, 0, 0, 0, 1, 0, "R9");

        // R7 device busy for a while: data delayed beyond the ready case
        exp_page(24'h000777, 16'h0010, 16, 0, 0, 1, -(3 + 2 + 4 + 1));
        run("busy_hold", 0, 24'h000777, 16'h0010, 16, 0, 0, 1, -1, 0, 12, 0, 1, 0, "R7");

        // R7 timeout: ready never rises
        exp_page(24'h000001, 16'h0000, 16, 0, 0, 0, 0);
        run("timeout", 0, 24'h000001, 0, 16, 0, 0, 1, -1, 1, 0, 0, 3 + 20 + 3, 2, "R7");

        // R11 step error on first address byte
        push(0, 8'h00, 0, 1, 3);
        push(1, 8'h44, 0, 1, 4);
        run("step_err", 0, 24'h000002, 16'h0044, 16, 0, 0, 1, 2, 0, 0, 0, 1, 1, "R11");

        // R11 error on data step of a column change
        push(0, 8'h05, 0, 1, 9);
        push(1, 8'h10, 0, 1, 4);
        push(1, 8'h00, 0, 1, 4);
        push(0, 8'hE0, 0, 1, 9);
        push(2, 0, 7, 4 + 2, 9);
        run("data_err", 1, 0, 16'h0010, 7, 0, 0, 1, 5, 0, 0, 0, 1, 1, "R11");

        // R6 zero-length waits
        cfg_twb = 8'd0; cfg_trr = 8'd0; cfg_tccs = 8'd0;
        exp_page(24'h00FFFF, 16'hFFFF, 2, 0, 0, 1, 4);
        run("zero_wait_page", 0, 24'h00FFFF, 16'hFFFF, 2, 0, 0, 1, -1, 0, 0, 0, 1, 0, "R6");
        push(0, 8'h05, 0, 1, 9);
        push(1, 8'h01, 0, 1, 4);
        push(1, 8'h00, 0, 1, 4);
        push(0, 8'hE0, 0, 1, 9);
        push(2, 0, 1, 2, 9);
        run("zero_wait_col", 1, 0, 16'h0001, 1, 0, 0, 1, -1, 0, 0, 0, 1, 0, "R6");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        chk(1'b0, "R2", "watchdog expired", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule